// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns a stream of 4-bit transmit nibbles into the three-level line signal of a 100 Mbit/s twisted-pair link. The whole block runs on one 125 MHz clock. An internal divide-by-five produces a one-cycle nibble strobe, which gives the 25 MHz nibble rate. The block puts that strobe on a port, and the MAC side presents its next nibble, enable and error flag whenever the strobe is high. On each strobe the framer registers one 5-bit code-group:

- the line idle group while no frame is in progress;
- start delimiters in place of the first two preamble nibbles;
- end delimiters after enable falls;
- the error group for any nibble flagged as bad;
- otherwise the data group for the nibble.

Each code-group is loaded into a five-stage shift register and sent one bit per clock. Every serial bit is XORed with the output of a free-running 11-bit scrambler. The result drives an NRZI toggle stage, and the NRZI stage drives a four-phase MLT-3 sequencer. The line output is the MLT-3 level as a signed 2-bit value.

A receiver recovers the bit stream by noting which clock cycles change the output level. It then descrambles the bits and regroups them into fives. The scrambler needs no alignment with the receiver: any 11 consecutive scrambled idle bits reveal its state.

Top module: `fxtx_line_encoder`

## Requirements
- R1: While reset is asserted, the line output is 0 and the strobe is low. After reset, the line carries only idle groups (11111) while transmit-enable is low.
- R2: `nib_strobe_o` is high for exactly one clock in every five. The nibble inputs are sampled at the rising clock edge that ends a strobe cycle.
- R3: Inside a frame, each nibble value 0..F maps to one of these groups, in nibble order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: The first two nibbles sampled with enable high are replaced by 11000 and then 10001.
- R5: At the first nibble sampled with enable low after a frame, the framer sends 01101 and then 00111, then returns to idle.
- R6: A frame nibble sampled with both enable and error high is sent as 00100 instead of its data group.
- R7: The error input has no effect while no frame is in progress: the line keeps sending idle groups.
- R8: Each serial bit is XORed with the keystream bit k = s[10] XOR s[8] of an 11-bit shift register, where s[10] is the oldest bit. After each bit, k is shifted in at s[0]. The register is seeded to a nonzero value and never becomes zero.
- R9: Each group is sent one bit per clock, with bit 4 (the leftmost bit above) first. Five bits are sent per strobe period.
- R10: The line output changes level in exactly the cycles that carry a scrambled 1. The levels cycle 0, +1, 0, -1, starting toward +1 after reset. The level is coded as 00 for 0, 01 for +1 and 11 for -1; 10 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en_i | input | 1 | Transmit enable, sampled on the strobe |
| tx_er_i | input | 1 | Transmit error, sampled on the strobe |
| txd_i | input | 4 | Transmit nibble, sampled on the strobe |
| nib_strobe_o | output | 1 | One-cycle strobe: inputs are taken at the edge that ends it |
| mlt_o | output | 2 | Signed MLT-3 line level (00 = 0, 01 = +1, 11 = -1) |

## Verification
A scrambler state that is corrupted or stuck shows up at the port within a few dozen bit times. Idle groups, once descrambled by a receiver that synchronized earlier, then stop decoding as all ones. A framer in the wrong state changes the sequence of groups around a frame: the start groups, the end groups, the error group or the data group appears one strobe period early or late, or not at all. An NRZI or MLT-3 fault appears within one or two clocks as an illegal level, a step that skips zero or repeats a direction, or a missing change for a scrambled 1.

// File: rtl/fxtx_pkg.sv
package fxtx_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [CG_W-1:0] cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_SSD1 = 5'b11000;
  localparam cg_t CG_SSD2 = 5'b10001;
  localparam cg_t CG_ESD1 = 5'b01101;
  localparam cg_t CG_ESD2 = 5'b00111;
  localparam cg_t CG_ERR  = 5'b00100;

  typedef enum logic [1:0] {FR_IDLE, FR_START2, FR_DATA, FR_END2} fr_state_e;

  function automatic cg_t data_group(input logic [NIB_W-1:0] nib);
    cg_t g;
    unique case (nib)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/fxtx_nibble_framer.sv
module fxtx_nibble_framer
  import fxtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  output cg_t              cg_o
);
  fr_state_e st_q, st_d;
  cg_t       cg_q, cg_d;

  always_comb begin
    st_d = st_q;
    cg_d = cg_q;
    unique case (st_q)
      FR_IDLE: begin
        if (tx_en_i) begin
          cg_d = CG_SSD1;
          st_d = FR_START2;
        end else begin
          cg_d = CG_IDLE;
        end
      end
      FR_START2: begin
        cg_d = CG_SSD2;
        st_d = FR_DATA;
      end
      FR_DATA: begin
        if (!tx_en_i) begin
          cg_d = CG_ESD1;
          st_d = FR_END2;
        end else if (tx_er_i) begin
          cg_d = CG_ERR;
        end else begin
          cg_d = data_group(txd_i);
        end
      end
      default: begin
        cg_d = CG_ESD2;
        st_d = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FR_IDLE;
      cg_q <= CG_IDLE;
    end else if (strobe_i) begin
      st_q <= st_d;
      cg_q <= cg_d;
    end
  end

  assign cg_o = cg_q;

  AST_SSD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && cg_q == CG_SSD1) |=> (cg_q == CG_SSD2)); // R4
  AST_ESD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && cg_q == CG_ESD1) |=> (cg_q == CG_ESD2)); // R5
  AST_ERR_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && st_q == FR_DATA && tx_en_i && tx_er_i) |=> (cg_q == CG_ERR)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && st_q == FR_IDLE && !tx_en_i) |=> (cg_q == CG_IDLE)); // R7
endmodule

// File: rtl/fxtx_scramble_serializer.sv
module fxtx_scramble_serializer
  import fxtx_pkg::*;
#(
  parameter int              LFSR_W = 11,
  parameter int              TAP_HI = 11,
  parameter int              TAP_LO = 9,
  parameter logic [LFSR_W-1:0] SEED = '1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  cg_t  cg_i,
  output logic sbit_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  cg_t               sh_q, sh_d;
  logic              key;

  always_comb begin
    key    = lfsr_q[TAP_HI-1] ^ lfsr_q[TAP_LO-1];
    lfsr_d = {lfsr_q[LFSR_W-2:0], key};
    sh_d   = load_i ? cg_i : {sh_q[CG_W-2:0], 1'b1};
    sbit_o = sh_q[CG_W-1] ^ key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      sh_q   <= CG_IDLE;
    end else begin
      lfsr_q <= lfsr_d;
      sh_q   <= sh_d;
    end
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr_q != '0)); // R8
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sh_q == $past(cg_i))); // R9
endmodule

// File: rtl/fxtx_nrzi_mlt3.sv
module fxtx_nrzi_mlt3 (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbit_i,
  output logic signed [1:0] mlt_o
);
  logic       nrzi_q, nrzi_d;
  logic       nrzi_prev_q;
  logic [1:0] ph_q, ph_d;

  always_comb begin
    nrzi_d = nrzi_q ^ sbit_i;
    ph_d   = ph_q + {1'b0, nrzi_q ^ nrzi_prev_q};
    unique case (ph_q)
      2'd1:    mlt_o = 2'sb01;
      2'd3:    mlt_o = 2'sb11;
      default: mlt_o = 2'sb00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q      <= 1'b0;
      nrzi_prev_q <= 1'b0;
      ph_q        <= 2'd0;
    end else begin
      nrzi_q      <= nrzi_d;
      nrzi_prev_q <= nrzi_q;
      ph_q        <= ph_d;
    end
  end

  AST_MLT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt_o != 2'sb10)); // R10
  AST_MLT_VIA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mlt_o) |-> ((mlt_o == 2'sb00) != ($past(mlt_o) == 2'sb00))); // R10
  AST_NRZI_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sbit_i |=> (nrzi_q != $past(nrzi_q))); // R10
endmodule

// File: rtl/fxtx_line_encoder.sv
module fxtx_line_encoder
  import fxtx_pkg::*;
#(
  parameter int               LFSR_W = 11,
  parameter int               TAP_HI = 11,
  parameter int               TAP_LO = 9,
  parameter logic [LFSR_W-1:0] SEED  = '1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [3:0]        txd_i,
  output logic              nib_strobe_o,
  output logic signed [1:0] mlt_o
);
  localparam int CNT_W = $clog2(CG_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CG_W - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;
  cg_t              cg;
  logic             sbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    nib_strobe_o = (cnt_q == CNT_LAST);
    load         = (cnt_q == '0);
    cnt_d        = nib_strobe_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  fxtx_nibble_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (nib_strobe_o),
    .tx_en_i  (tx_en_i),
    .tx_er_i  (tx_er_i),
    .txd_i    (txd_i),
    .cg_o     (cg)
  );

  fxtx_scramble_serializer #(
    .LFSR_W (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .SEED   (SEED)
  ) u_scram (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .cg_i   (cg),
    .sbit_o (sbit)
  );

  fxtx_nrzi_mlt3 u_line (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sbit_i (sbit),
    .mlt_o  (mlt_o)
  );

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    nib_strobe_o |=> !nib_strobe_o); // R2
  AST_STROBE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    nib_strobe_o |=> load); // R2
endmodule

// File: tb/tb_fxtx_line_encoder.sv
module tb_fxtx_line_encoder;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_en = 1'b0;
  logic              tx_er = 1'b0;
  logic [3:0]        txd = 4'h0;
  logic              strobe;
  logic signed [1:0] mlt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fxtx_line_encoder dut (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .tx_er_i(tx_er),
    .txd_i(txd), .nib_strobe_o(strobe), .mlt_o(mlt)
  );

  localparam logic [4:0] G_I = 5'b11111, G_J = 5'b11000, G_K = 5'b10001,
                         G_T = 5'b01101, G_R = 5'b00111, G_H = 5'b00100;

  function automatic logic [4:0] enc_ref(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100;
      4'h3: return 5'b10101; 4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111; 4'h8: return 5'b10010;
      4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Receiver model: level change = 1, self-synchronising descrambler, regroup by 5
  bit               mon_on = 0;
  int               sync_cnt = 0;
  logic [10:0]      ks = '0;
  logic [4:0]       sr = '1;
  logic signed [1:0] prev_mlt = 0;
  logic signed [1:0] last_nz = 2'sb11;
  bit               s1 = 0, s2 = 0, s3 = 0;
  int               mlt_bad = 0;
  int               n_tr = 0;
  logic [4:0]       grp_q[$];

  always @(negedge clk) begin
    if (mon_on) begin
      logic r, key, plain;
      r = (mlt !== prev_mlt);
      if (r) begin
        n_tr++;
        if (mlt == 2'sb10) mlt_bad++;
        else if (prev_mlt != 0) begin
          if (mlt != 0) mlt_bad++;
          last_nz = prev_mlt;
        end else if (mlt != ((last_nz == 2'sb01) ? 2'sb11 : 2'sb01)) mlt_bad++;
      end
      prev_mlt = mlt;
      if (sync_cnt < 40) begin
        key = ~r;
        plain = 1'b1;
        sync_cnt++;
      end else begin
        key = ks[10] ^ ks[8];
        plain = r ^ key;
      end
      ks = {ks[9:0], key};
      sr = {sr[3:0], plain};
      if (s3 && sync_cnt >= 40) grp_q.push_back(sr);
      s3 = s2; s2 = s1; s1 = strobe;
    end
  end

  task automatic drive(input logic en, input logic er, input logic [3:0] d);
    do @(negedge clk); while (!strobe);
    tx_en = en; tx_er = er; txd = d;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "mlt in reset", mlt, 0);
    chk("R1", "strobe in reset", strobe, 0);
    rst_n = 1'b1;
    mon_on = 1;
  endtask

  task automatic t_strobe();
    for (int k = 0; k < 3; k++) begin
      int gap;
      do @(negedge clk); while (!strobe);
      @(negedge clk);
      chk("R2", "strobe width", strobe, 0);
      gap = 1;
      while (!strobe) begin @(negedge clk); gap++; end
      chk("R2", "strobe period", gap, 5);
    end
  endtask

  task automatic t_idle();
    int bad = 0;
    repeat (60) @(negedge clk);
    grp_q.delete();
    repeat (60) @(negedge clk);
    foreach (grp_q[i]) if (grp_q[i] != G_I) bad++;
    chk("R8", "descrambler synced", (sync_cnt >= 40), 1);
    chk("R1 R8", "idle groups seen", (grp_q.size() >= 10), 1);
    chk("R1 R8", "non-idle groups in idle", bad, 0);
  endtask

  logic [3:0] f_nib[32];
  logic       f_er[32];
  int         f_n;

  task automatic run_frame(input string tag);
    int j;
    grp_q.delete();
    for (int i = 0; i < f_n; i++) drive(1'b1, f_er[i], f_nib[i]);
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, 4'h0);
    repeat (20) @(negedge clk);
    j = -1;
    foreach (grp_q[i]) if (j < 0 && grp_q[i] != G_I) j = i;
    if (j < 0 || j + f_n + 2 >= grp_q.size()) begin
      chk("R4", {tag, " frame found"}, 0, 1);
      return;
    end
    chk("R4", {tag, " first start group"}, grp_q[j], G_J);
    chk("R4", {tag, " second start group"}, grp_q[j+1], G_K);
    for (int i = 2; i < f_n; i++)
      if (f_er[i]) chk("R6", {tag, " error group"}, grp_q[j+i], G_H);
      else         chk("R3 R9", {tag, " data group"}, grp_q[j+i], enc_ref(f_nib[i]));
    chk("R5", {tag, " first end group"}, grp_q[j+f_n], G_T);
    chk("R5", {tag, " second end group"}, grp_q[j+f_n+1], G_R);
    chk("R1", {tag, " idle after frame"}, grp_q[j+f_n+2], G_I);
  endtask

  task automatic t_all_nibbles();
    f_n = 18;
    f_nib[0] = 4'h5; f_nib[1] = 4'h5; f_er[0] = 0; f_er[1] = 0;
    for (int i = 0; i < 16; i++) begin f_nib[i+2] = 4'(i); f_er[i+2] = 0; end
    run_frame("all nibbles");
  endtask

  task automatic t_error_frame();
    f_n = 8;
    for (int i = 0; i < 8; i++) begin f_nib[i] = 4'(9 - i); f_er[i] = 0; end
    f_er[3] = 1; f_er[6] = 1;
    run_frame("error frame");
  endtask

  task automatic t_short_frame();
    f_n = 2;
    f_nib[0] = 4'hD; f_nib[1] = 4'hD; f_er[0] = 1; f_er[1] = 0;
    run_frame("short frame");
  endtask

  task automatic t_err_outside();
    int bad = 0;
    grp_q.delete();
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1, 4'hA);
    drive(1'b0, 1'b0, 4'h0);
    repeat (20) @(negedge clk);
    foreach (grp_q[i]) if (grp_q[i] != G_I) bad++;
    chk("R7", "groups observed", (grp_q.size() >= 8), 1);
    chk("R7", "non-idle while error outside frame", bad, 0);
  endtask

  task automatic t_line_levels();
    chk("R10", "illegal MLT-3 steps", mlt_bad, 0);
    chk("R10", "level changes seen", (n_tr > 50), 1);
  endtask

  initial begin
    t_reset();
    t_strobe();
    t_idle();
    t_all_nibbles();
    t_error_frame();
    t_short_frame();
    t_err_outside();
    t_line_levels();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule